// File: doc/BRIEF.md
# System Clock Prescaler and Output Selector

This block turns a set of source-clock enable pulses into the enable strobes a clock tree needs. A configuration word, loaded through a write strobe, chooses which source pulse train acts as the system tick. It sets a power-of-two division for a high-speed bus, and a further division for each of two peripheral buses that count high-speed strobes. A separate path picks one of seven auxiliary pulse trains, or none, and divides it to drive a clock-output enable.

The prescaler codes are non-linear. Every code below a threshold means divide-by-1, and each code above it doubles the ratio. The output-select code 0 turns the output path off. Every nonzero code N points at auxiliary input N-1. A read-only status field echoes the selected system source one cycle after the stored word changes.

All strobes are single-cycle enables. Each one is high in the same cycle as the input pulse that completes its count. Nothing here gates a real clock.

Top module: `sysclk_presc_mux`

## Requirements
- R1: After reset the stored word is zero: system source 0, every bus at divide-by-1, output path off, `sw_status` = 0 and `out_pre_err` = 0.
- R2: Word bits [1:0] select the system tick as `sys_src_pulse[sel]`. Pulses on the other inputs produce no bus strobes.
- R3: `sw_status` shows the system-select bits of the stored word one cycle after the stored word changes. A write with `cfg_we` at edge k shows on `sw_status` after edge k+1.
- R4: Word bits [5:2] are the high-speed code. Codes 0 to 7 divide by 1 and codes 8 to 15 divide by 2^(code-7). `hs_en` fires on every Nth system tick.
- R5: Bits [8:6] and [11:9] are the two peripheral codes. Both use the same encoding: codes 0 to 3 divide by 1 and codes 4 to 7 divide by 2^(code-3). Each divides `hs_en` independently into `pb1_en` and `pb2_en`.
- R6: Bits [14:12] are the output select. Code 0 holds `out_en` low. A nonzero code N divides `out_src_pulse[N-1]`.
- R7: Bits [17:15] are the output prescaler code, which divides by 2^code for codes 0 to 4. Codes 5 to 7 divide by 16 and drive `out_pre_err` high.
- R8: From reset, a divider of ratio N emits exactly floor(T/N) strobes over T input pulses, the first on the Nth pulse.
- R9: When a code drops below the progress already counted, the divider strobes on the very next input pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load the configuration word |
| cfg_wdata | input | 18 | Configuration word |
| sys_src_pulse | input | 4 | Candidate system tick pulses |
| out_src_pulse | input | 7 | Candidate output-path pulses |
| hs_en | output | 1 | High-speed bus enable strobe |
| pb1_en | output | 1 | First peripheral bus enable strobe |
| pb2_en | output | 1 | Second peripheral bus enable strobe |
| out_en | output | 1 | Clock-output enable strobe |
| sw_status | output | 2 | Echo of the active system-select code |
| out_pre_err | output | 1 | Output prescaler code is reserved |

## Verification
The bench uses the package defaults: four system sources, seven output sources and 8-bit divider counters. These widths make the full divide-by-256 high-speed ratio reachable in 512 ticks. They also allow the deepest cascade, high-speed times peripheral, to be observed as a zero or two-strobe count. The seven-way output selector lets every select code be tried against a single active input. This shows that code N routes input N-1, while a mismatched input yields nothing.

// File: rtl/sysclk_presc_pkg.sv
`timescale 1ns/1ps
package sysclk_presc_pkg;
    localparam int SYS_N  = 4;
    localparam int SW_W   = $clog2(SYS_N);
    localparam int OUT_N  = 7;
    localparam int OSEL_W = $clog2(OUT_N + 1);
    localparam int HS_W   = 4;
    localparam int PB_W   = 3;
    localparam int OP_W   = 3;
    localparam int CNT_W  = 8;
    localparam int CFG_W  = SW_W + HS_W + 2 * PB_W + OSEL_W + OP_W;
    localparam int HS_KNEE = 7;
    localparam int PB_KNEE = 3;
    localparam int OP_MAX  = 4;

    typedef struct packed {
        logic [OP_W-1:0]   opre;
        logic [OSEL_W-1:0] osel;
        logic [PB_W-1:0]   pb2;
        logic [PB_W-1:0]   pb1;
        logic [HS_W-1:0]   hs;
        logic [SW_W-1:0]   sw;
    } cfg_t;

    // terminal count (ratio - 1) for a ratio of 2^e
    function automatic logic [CNT_W-1:0] lim_of_exp(input int e);
        return CNT_W'((1 << e) - 1);
    endfunction

    // codes at or below the knee mean divide-by-1
    function automatic int knee_exp(input int code, input int knee);
        return (code > knee) ? code - knee : 0;
    endfunction
endpackage

// File: rtl/clk_en_div.sv
`timescale 1ns/1ps
module clk_en_div #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic [CW-1:0] lim,
    output logic          strobe
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_t;

    div_t st_d, st_q;
    logic hit;

    always_comb begin
        st_d = st_q;
        hit  = run && tick && (st_q.cnt >= lim);
        if (!run) begin
            st_d.cnt = '0;
        end else if (hit) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign strobe = hit;
endmodule

// File: rtl/sysclk_presc_mux.sv
`timescale 1ns/1ps
module sysclk_presc_mux
    import sysclk_presc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic [SYS_N-1:0]  sys_src_pulse,
    input  logic [OUT_N-1:0]  out_src_pulse,
    output logic              hs_en,
    output logic              pb1_en,
    output logic              pb2_en,
    output logic              out_en,
    output logic [SW_W-1:0]   sw_status,
    output logic              out_pre_err
);
    typedef struct packed {
        cfg_t            cfg;
        logic [SW_W-1:0] stat;
    } top_t;

    top_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.stat = st_q.cfg.sw;
        if (cfg_we) st_d.cfg = cfg_t'(cfg_wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // system tick source
    logic sys_tick;
    assign sys_tick = sys_src_pulse[st_q.cfg.sw];

    // high-speed bus
    logic [CNT_W-1:0] hs_lim;
    assign hs_lim = lim_of_exp(knee_exp(int'(st_q.cfg.hs), HS_KNEE));

    clk_en_div #(.CW(CNT_W)) u_hs_div (
        .clk(clk), .rst_n(rst_n), .run(1'b1), .tick(sys_tick),
        .lim(hs_lim), .strobe(hs_en)
    );

    // peripheral buses, same encoding, cascaded from hs_en
    logic [PB_W-1:0] pb_code [2];
    logic [1:0]      pb_strobe;
    assign pb_code[0] = st_q.cfg.pb1;
    assign pb_code[1] = st_q.cfg.pb2;

    for (genvar g = 0; g < 2; g++) begin : g_pb
        logic [CNT_W-1:0] lim_g;
        assign lim_g = lim_of_exp(knee_exp(int'(pb_code[g]), PB_KNEE));
        clk_en_div #(.CW(CNT_W)) u_pb_div (
            .clk(clk), .rst_n(rst_n), .run(1'b1), .tick(hs_en),
            .lim(lim_g), .strobe(pb_strobe[g])
        );
    end
    assign pb1_en = pb_strobe[0];
    assign pb2_en = pb_strobe[1];

    // clock-output path
    logic             out_on;
    logic             out_tick;
    logic             pre_bad;
    logic [CNT_W-1:0] out_lim;

    assign out_on   = (st_q.cfg.osel != '0);
    assign out_tick = out_on ? out_src_pulse[st_q.cfg.osel - OSEL_W'(1)] : 1'b0;
    assign pre_bad  = (int'(st_q.cfg.opre) > OP_MAX);
    assign out_lim  = lim_of_exp(pre_bad ? OP_MAX : int'(st_q.cfg.opre));

    clk_en_div #(.CW(CNT_W)) u_out_div (
        .clk(clk), .rst_n(rst_n), .run(out_on), .tick(out_tick),
        .lim(out_lim), .strobe(out_en)
    );

    assign sw_status   = st_q.stat;
    assign out_pre_err = pre_bad;
endmodule

// File: rtl/sysclk_presc_mux_chk.sv
`timescale 1ns/1ps
module sysclk_presc_mux_chk
    import sysclk_presc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [CFG_W-1:0]  cfg_wdata,
    input logic [SYS_N-1:0]  sys_src_pulse,
    input logic [OUT_N-1:0]  out_src_pulse,
    input logic              hs_en,
    input logic              pb1_en,
    input logic              pb2_en,
    input logic              out_en,
    input logic [SW_W-1:0]   sw_status,
    input logic              out_pre_err
);
    // R2
    hs_needs_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_en |-> (sys_src_pulse != '0));
    // R5
    pb1_cascade_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pb1_en |-> hs_en);
    // R5
    pb2_cascade_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pb2_en |-> hs_en);
    // R6
    out_needs_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |-> (out_src_pulse != '0));
    // R3
    status_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> ##1 (sw_status == $past(cfg_wdata[SW_W-1:0], 2)));
    // R7
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_we) |-> $stable(out_pre_err));
endmodule

bind sysclk_presc_mux sysclk_presc_mux_chk u_chk (.*);

// File: tb/sysclk_presc_mux_tb.sv
`timescale 1ns/1ps
module sysclk_presc_mux_tb;
    import sysclk_presc_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [CFG_W-1:0]  cfg_wdata = '0;
    logic [SYS_N-1:0]  sys_src_pulse = '0;
    logic [OUT_N-1:0]  out_src_pulse = '0;
    logic              hs_en, pb1_en, pb2_en, out_en, out_pre_err;
    logic [SW_W-1:0]   sw_status;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sysclk_presc_mux u_dut (.*);

    typedef struct packed {
        logic [2:0]  opre;
        logic [2:0]  osel;
        logic [2:0]  pb2;
        logic [2:0]  pb1;
        logic [3:0]  hs;
        logic [1:0]  sw;
        logic [1:0]  sj;
        logic [2:0]  ok;
        logic [15:0] e_hs;
        logic [15:0] e_p1;
        logic [15:0] e_p2;
        logic [15:0] e_out;
        logic        e_err;
    } vec_t;

    localparam int TLEN = 512;
    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 3'd1, 3'd0, 3'd0, 4'd0,  2'd0, 2'd0, 3'd0, 16'd512, 16'd512, 16'd512, 16'd512, 1'b0},
        '{3'd2, 3'd3, 3'd5, 3'd4, 4'd8,  2'd1, 2'd1, 3'd2, 16'd256, 16'd128, 16'd64,  16'd128, 1'b0},
        '{3'd4, 3'd7, 3'd7, 3'd3, 4'd7,  2'd2, 2'd2, 3'd6, 16'd512, 16'd512, 16'd32,  16'd32,  1'b0},
        '{3'd5, 3'd2, 3'd6, 3'd0, 4'd15, 2'd3, 2'd3, 3'd1, 16'd2,   16'd2,   16'd0,   16'd32,  1'b1},
        '{3'd1, 3'd0, 3'd0, 3'd7, 4'd9,  2'd1, 2'd0, 3'd0, 16'd0,   16'd0,   16'd0,   16'd0,   1'b0},
        '{3'd3, 3'd4, 3'd4, 3'd5, 4'd12, 2'd0, 2'd0, 3'd2, 16'd16,  16'd4,   16'd8,   16'd0,   1'b0},
        '{3'd7, 3'd5, 3'd3, 3'd6, 4'd10, 2'd2, 2'd2, 3'd4, 16'd64,  16'd8,   16'd64,  16'd32,  1'b1}
    };

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0; cfg_we = 1'b0;
        sys_src_pulse = '0; out_src_pulse = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic write_cfg(input logic [CFG_W-1:0] w);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_wdata = w;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic run(input int sj, input int ok, input int t,
                       output int c_hs, output int c_p1, output int c_p2, output int c_out);
        c_hs = 0; c_p1 = 0; c_p2 = 0; c_out = 0;
        for (int i = 0; i < t; i++) begin
            @(posedge clk); #1;
            sys_src_pulse = '0; sys_src_pulse[sj] = 1'b1;
            out_src_pulse = '0; out_src_pulse[ok] = 1'b1;
            @(negedge clk);
            c_hs += int'(hs_en); c_p1 += int'(pb1_en);
            c_p2 += int'(pb2_en); c_out += int'(out_en);
        end
        @(posedge clk); #1;
        sys_src_pulse = '0; out_src_pulse = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int a, b, c, d;

        // R1: reset state
        do_reset();
        @(negedge clk);
        check("R1 sw_status", int'(sw_status), 0);
        check("R1 out_pre_err", int'(out_pre_err), 0);
        check("R1 hs_en idle", int'(hs_en), 0);
        run(0, 0, 1, a, b, c, d);
        check("R1 hs div1", a, 1);
        check("R1 pb1 div1", b, 1);
        check("R1 pb2 div1", c, 1);
        check("R1 out off", d, 0);

        // R3: status lags the stored word by one cycle
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_wdata = CFG_W'(2);
        @(posedge clk); #1;
        cfg_we = 1'b0;
        @(negedge clk);
        check("R3 status before echo", int'(sw_status), 0);
        @(negedge clk);
        check("R3 status after echo", int'(sw_status), 2);

        // vector table: R2 R4 R5 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            do_reset();
            write_cfg({VEC[v].opre, VEC[v].osel, VEC[v].pb2, VEC[v].pb1, VEC[v].hs, VEC[v].sw});
            run(int'(VEC[v].sj), int'(VEC[v].ok), TLEN, a, b, c, d);
            check($sformatf("R4 R2 R8 hs count vec %0d", v), a, int'(VEC[v].e_hs));
            check($sformatf("R5 pb1 count vec %0d", v), b, int'(VEC[v].e_p1));
            check($sformatf("R5 pb2 count vec %0d", v), c, int'(VEC[v].e_p2));
            check($sformatf("R6 R7 out count vec %0d", v), d, int'(VEC[v].e_out));
            check($sformatf("R7 err flag vec %0d", v), int'(out_pre_err), int'(VEC[v].e_err));
            check($sformatf("R3 status vec %0d", v), int'(sw_status), int'(VEC[v].sw));
        end

        // R9: lowering the code past the counted progress strobes at once
        do_reset();
        write_cfg({3'd0, 3'd0, 3'd0, 3'd0, 4'd15, 2'd0});
        run(0, 0, 100, a, b, c, d);
        check("R9 no strobe before 256", a, 0);
        write_cfg({3'd0, 3'd0, 3'd0, 3'd0, 4'd9, 2'd0});
        run(0, 0, 1, a, b, c, d);
        check("R9 immediate strobe", a, 1);
        run(0, 0, 3, a, b, c, d);
        check("R9 R8 quiet gap", a, 0);
        run(0, 0, 1, a, b, c, d);
        check("R9 R8 fourth tick", a, 1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule